// File: doc/BRIEF.md
# ADC Trigger and Conversion-End Flag Controller

This block is the digital sequencing logic that sits beside an analog-to-digital converter core. Software programs a small 8-bit control register: scan mode, hardware-trigger enable, a flag policy bit, a conversion-time select and a start bit. Conversions are launched in two ways. Software can set the start bit while hardware triggering is off. Otherwise a rising edge on one of three trigger inputs launches them: an external pin, timer trigger A and timer trigger B. The pin and timer A belong to group 0 and timer B belongs to group 1. A down-counter stands in for the analog core. It holds `busy` high for the length of one pass, and that length depends on the selected per-channel state count and on the number of channels the mode scans.

When a pass completes, the block pulses the `grp_done` bit of the group that launched it and updates a sticky end flag. Normally the flag is set on every completion. In 2-channel scan with hardware triggering enabled, the policy bit can instead make the flag wait until both groups have completed, in either order. Two internal per-group latches record progress toward that point. Mode and timing fields are frozen while the start bit is set, so software changes them only while the block is stopped.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `busy`, `grp_done` and `end_flag` are all 0. Register layout: bit0 start, bits2:1 mode (0 single, 1 two-channel scan, 2 four-channel scan, 3 eight-channel scan), bit3 reserved, bit4 hardware-trigger enable, bit5 both-groups flag policy, bit6 long state count, bit7 end flag.
- R2: Bit 3 of `rd_data` always reads 0, whatever value is written to it.
- R3: While the start bit reads 1, a write leaves bits 6:4 and 2:1 unchanged. The start bit and the end-flag bit are still written.
- R4: A rising edge on `trg_pin`, `tmr_trg_a` or `tmr_trg_b` is ignored while bit4 is 0. While bit4 is 1 it launches a conversion, and `busy` goes high after the third rising clock edge counted from the first edge that samples the input high.
- R5: A pass lasts (bit6 ? 64 : 50) multiplied by 1, 2, 4 or 8 clock cycles for modes 0 to 3. `busy` stays high for exactly that many cycles, and `grp_done` pulses for one cycle starting at the edge where `busy` falls.
- R6: A trigger that arrives while `busy` is high is dropped and is not served later.
- R7: When group-0 and group-1 triggers are detected in the same cycle, the group-0 pass runs first. The group-1 pass follows with no gap, so `busy` stays high for two full passes. `grp_done` is 01 for group 0 and 10 for group 1, and at most one of its bits is high at a time.
- R8: Unless mode is 1, bit4 is 1 and bit5 is 1, `end_flag` is set at the same edge as every completion. In particular bit5 is ignored in modes 0, 2 and 3.
- R9: In mode 1 with bits 4 and 5 set, `end_flag` is set only at the completion that gives both groups a completion since the latches were last cleared, whichever group came first. The latches clear when the flag is set and while the start bit is 0.
- R10: `end_flag` stays set until a write with bit7 = 0 clears it. A write with bit7 = 1 has no effect on it.
- R11: In mode 0 the start bit clears itself when a pass completes. In modes 1 to 3 it stays 1 until software writes it to 0. A hardware launch sets the start bit.
- R12: With bit4 written 0, writing the start bit from 0 to 1 launches a group-0 pass at that write edge, so `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| trg_pin | input | 1 | External trigger, group 0, asynchronous |
| tmr_trg_a | input | 1 | Timer trigger A, group 0, asynchronous |
| tmr_trg_b | input | 1 | Timer trigger B, group 1, asynchronous |
| busy | output | 1 | A conversion pass is in progress |
| grp_done | output | 2 | One-cycle completion pulse per group |
| end_flag | output | 1 | Sticky conversion-end flag |

## Verification
A software start makes `busy` high right after the write edge, so its completion is due 1 + L cycles after the write is driven. A hardware trigger passes through two synchroniser stages and an edge detector, so its completion is due 3 + L cycles after the input rises. A second group queued behind a simultaneous trigger finishes a further L cycles later. Every stimulus task records the cycle it drove and pushes the predicted completion cycle, group and end-flag value into a queue. The monitor compares each `grp_done` pulse with the head of that queue, so an early, late, missing or extra completion counts as a miscompare. Checks that a trigger was dropped or ignored sample `busy` right after the point where a launch would have appeared. The monitor also rejects any completion pulse that no item predicts.

// File: rtl/adc_tc_pkg.sv
package adc_tc_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SCAN2  = 2'd1,
    MODE_SCAN4  = 2'd2,
    MODE_SCAN8  = 2'd3
  } scan_mode_e;

  // control register bit positions (software-visible layout)
  localparam int REG_W     = 8;
  localparam int BIT_START = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_RSVD  = 3;
  localparam int BIT_TRGEN = 4;
  localparam int BIT_FCTL  = 5;
  localparam int BIT_SLOW  = 6;
  localparam int BIT_END   = 7;

  typedef struct packed {
    logic       slow;
    logic       fctl;
    logic       trg_en;
    scan_mode_e mode;
  } cfg_t;

  function automatic int unsigned chan_count(scan_mode_e m);
    return 32'd1 << m;
  endfunction

  function automatic int unsigned pass_len(cfg_t c, int unsigned fast_st,
                                           int unsigned slow_st);
    return (c.slow ? slow_st : fast_st) * chan_count(c.mode);
  endfunction

  function automatic logic both_policy(cfg_t c);
    return (c.mode == MODE_SCAN2) && c.trg_en && c.fctl;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int NUM    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] trig_in,
  output logic [NUM-1:0] rise
);

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_in
      logic [STAGES-1:0] sh_q;
      logic              prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q   <= '0;
          prev_q <= 1'b0;
        end else begin
          sh_q   <= {sh_q[STAGES-2:0], trig_in[g]};
          prev_q <= sh_q[STAGES-1];
        end
      end
      assign rise[g] = sh_q[STAGES-1] & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_tc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             launch,
  input  logic             auto_clr,
  input  logic             end_flag,
  output cfg_t             cfg_q,
  output cfg_t             cfg_eff,
  output logic             start_q,
  output logic             sw_go,
  output logic             sw_stop,
  output logic [REG_W-1:0] rd_data
);

  localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1) << BIT_RSVD;

  logic [REG_W-1:0] wr_clean;
  cfg_t             cfg_wr;
  logic             cfg_open;

  always_comb begin
    wr_clean      = wr_data & ~RSVD_MASK;
    cfg_wr.slow   = wr_clean[BIT_SLOW];
    cfg_wr.fctl   = wr_clean[BIT_FCTL];
    cfg_wr.trg_en = wr_clean[BIT_TRGEN];
    cfg_wr.mode   = scan_mode_e'(wr_clean[BIT_MODE +: 2]);
    cfg_open      = wr_en && !start_q;
    cfg_eff       = cfg_open ? cfg_wr : cfg_q;
    sw_go         = cfg_open && wr_clean[BIT_START] && !cfg_wr.trg_en;
    sw_stop       = wr_en && start_q && !wr_clean[BIT_START];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (cfg_open) cfg_q <= cfg_wr;
      if (wr_en)         start_q <= wr_clean[BIT_START];
      else if (launch)   start_q <= 1'b1;
      else if (auto_clr) start_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[BIT_START]   = start_q;
    rd_data[BIT_MODE+:2] = cfg_q.mode;
    rd_data[BIT_TRGEN]   = cfg_q.trg_en;
    rd_data[BIT_FCTL]    = cfg_q.fctl;
    rd_data[BIT_SLOW]    = cfg_q.slow;
    rd_data[BIT_END]     = end_flag;
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req0,
  input  logic             req1,
  input  logic             abort,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             fin_evt,
  output logic             fin_grp,
  output logic             launch,
  output logic             launch_grp
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             grp_q;
  logic             pend1_q;

  always_comb begin
    fin_evt    = busy_q && (cnt_q == '0);
    fin_grp    = grp_q;
    launch     = 1'b0;
    launch_grp = 1'b0;
    if (!abort) begin
      if (!busy_q) begin
        if (req0) begin
          launch = 1'b1;
        end else if (req1) begin
          launch     = 1'b1;
          launch_grp = 1'b1;
        end
      end else if (fin_evt && pend1_q) begin
        launch     = 1'b1;
        launch_grp = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      grp_q   <= 1'b0;
      pend1_q <= 1'b0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      pend1_q <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      cnt_q   <= len - CNT_W'(1);
      grp_q   <= launch_grp;
      pend1_q <= !busy_q && req0 && req1;
    end else if (fin_evt) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/adc_end_flag.sv
module adc_end_flag (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin_evt,
  input  logic       fin_grp,
  input  logic       both_mode,
  input  logic       start_q,
  input  logic       clr_wr,
  output logic       end_flag,
  output logic [1:0] grp_done,
  output logic [1:0] lat_q
);

  logic [1:0] done_vec;
  logic [1:0] merged;
  logic       set_end;

  always_comb begin
    done_vec = fin_evt ? (fin_grp ? 2'b10 : 2'b01) : 2'b00;
    merged   = lat_q | done_vec;
    set_end  = fin_evt && (!both_mode || (merged == 2'b11));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag <= 1'b0;
      grp_done <= 2'b00;
      lat_q    <= 2'b00;
    end else begin
      grp_done <= done_vec;
      if (set_end)     end_flag <= 1'b1;
      else if (clr_wr) end_flag <= 1'b0;
      if (!start_q || set_end) lat_q <= 2'b00;
      else if (both_mode)      lat_q <= merged;
    end
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_tc_pkg::*;
#(
  parameter int FAST_STATES = 50,
  parameter int SLOW_STATES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             trg_pin,
  input  logic             tmr_trg_a,
  input  logic             tmr_trg_b,
  output logic             busy,
  output logic [1:0]       grp_done,
  output logic             end_flag
);

  localparam int MAX_ST  = (FAST_STATES > SLOW_STATES) ? FAST_STATES : SLOW_STATES;
  localparam int MAX_LEN = MAX_ST * 8;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [2:0]       trig_rise;
  cfg_t             cfg_q;
  cfg_t             cfg_eff;
  logic             start_q;
  logic             sw_go;
  logic             sw_stop;
  logic             hw_req0;
  logic             hw_req1;
  logic             fin_evt;
  logic             fin_grp;
  logic             launch;
  logic             launch_grp;
  logic             auto_clr;
  logic             both_mode;
  logic             clr_wr;
  logic [1:0]       lat_q;
  logic [CNT_W-1:0] len;

  adc_trig_sync #(.NUM(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in ({tmr_trg_b, tmr_trg_a, trg_pin}),
    .rise    (trig_rise)
  );

  assign hw_req0   = cfg_q.trg_en && (trig_rise[0] || trig_rise[1]);
  assign hw_req1   = cfg_q.trg_en && trig_rise[2];
  assign len       = CNT_W'(pass_len(cfg_eff, FAST_STATES, SLOW_STATES));
  assign auto_clr  = fin_evt && (cfg_q.mode == MODE_SINGLE);
  assign both_mode = both_policy(cfg_q);
  assign clr_wr    = wr_en && !wr_data[BIT_END];

  adc_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .launch   (launch),
    .auto_clr (auto_clr),
    .end_flag (end_flag),
    .cfg_q    (cfg_q),
    .cfg_eff  (cfg_eff),
    .start_q  (start_q),
    .sw_go    (sw_go),
    .sw_stop  (sw_stop),
    .rd_data  (rd_data)
  );

  adc_conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req0       (hw_req0 || sw_go),
    .req1       (hw_req1),
    .abort      (sw_stop),
    .len        (len),
    .busy       (busy),
    .fin_evt    (fin_evt),
    .fin_grp    (fin_grp),
    .launch     (launch),
    .launch_grp (launch_grp)
  );

  adc_end_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_evt   (fin_evt),
    .fin_grp   (fin_grp),
    .both_mode (both_mode),
    .start_q   (start_q),
    .clr_wr    (clr_wr),
    .end_flag  (end_flag),
    .grp_done  (grp_done),
    .lat_q     (lat_q)
  );

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             start_q,
  input logic [4:0]       cfg_bits,
  input logic             busy,
  input logic             fin_evt,
  input logic             launch,
  input logic             sw_go,
  input logic             both_mode,
  input logic             end_flag,
  input logic [1:0]       lat_q,
  input logic [1:0]       grp_done,
  input logic [CNT_W-1:0] len
);

  logic [CNT_W-1:0] exp_len_q;
  logic [CNT_W-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len_q <= '0;
      elapsed_q <= '0;
    end else if (launch) begin
      exp_len_q <= len;
      elapsed_q <= '0;
    end else if (busy) begin
      elapsed_q <= elapsed_q + CNT_W'(1);
    end
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> !rd_data[3]);

  assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> $stable(cfg_bits));

  assert_trig_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bits[2] && !sw_go && !busy) |-> !launch);

  assert_pass_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |-> (elapsed_q == exp_len_q - CNT_W'(1)));

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_evt) |-> !launch);

  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_done));

  assert_both_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (both_mode && fin_evt && !end_flag && (lat_q == 2'b00)) |=> !end_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !(wr_en && !wr_data[7])) |=> end_flag);

  assert_single_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && (cfg_bits[1:0] == 2'd0) && !launch && !wr_en) |=> !start_q);

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .start_q   (start_q),
  .cfg_bits  (cfg_q),
  .busy      (busy),
  .fin_evt   (fin_evt),
  .launch    (launch),
  .sw_go     (sw_go),
  .both_mode (both_mode),
  .end_flag  (end_flag),
  .lat_q     (lat_q),
  .grp_done  (grp_done),
  .len       (len)
);

// File: tb/adc_trig_ctrl_tb_top.sv
`timescale 1ns/100ps
module adc_trig_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       trg_pin = 1'b0;
  logic       tmr_trg_a = 1'b0;
  logic       tmr_trg_b = 1'b0;
  logic       busy;
  logic [1:0] grp_done;
  logic       end_flag;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    int         at;
    logic [1:0] grp;
    logic       flag;
    string      req;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_trig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trg_pin(trg_pin), .tmr_trg_a(tmr_trg_a),
    .tmr_trg_b(tmr_trg_b), .busy(busy), .grp_done(grp_done),
    .end_flag(end_flag)
  );

  function automatic logic [7:0] mk(bit st, logic [1:0] md, bit te, bit fc,
                                    bit sl, bit ef);
    return {ef, sl, fc, te, 1'b0, md, st};
  endfunction

  // pass length restated: per-channel states times channels scanned
  function automatic int plen(bit sl, int md);
    int st;
    int ch;
    st = sl ? 64 : 50;
    ch = 1;
    for (int k = 0; k < md; k++) ch = ch * 2;
    return st * ch;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every completion pulse
  always @(negedge clk) begin
    if (rst_n && grp_done != 2'b00) begin
      if (sbq.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R6 unexpected completion: actual grp %0d at %0d expected none",
                 grp_done, cyc);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, cyc, e.at, "completion cycle");
        chk(e.req, int'(grp_done), int'(e.grp), "completion group");
        chk(e.req, int'(end_flag), int'(e.flag), "end flag at completion");
      end
    end
  end

  task automatic push(int at, logic [1:0] g, logic f, string req);
    exp_t e;
    e.at = at; e.grp = g; e.flag = f; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(bit p, bit a, bit b);
    trg_pin = p; tmr_trg_a = a; tmr_trg_b = b;
    repeat (2) @(negedge clk);
    trg_pin = 1'b0; tmr_trg_a = 1'b0; tmr_trg_b = 1'b0;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    int c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rd_data, 0, "rd_data after reset");
    chk("R1", busy, 0, "busy after reset");
    chk("R1", grp_done, 0, "grp_done after reset");
    chk("R1", end_flag, 0, "end_flag after reset");

    // R2 reserved bit, R10 writing 1 to flag does nothing
    wr(mk(0, 2'd0, 0, 0, 0, 1) | 8'h08);
    chk("R2", rd_data, mk(0, 2'd0, 0, 0, 0, 0), "reserved bit readback");
    chk("R10", end_flag, 0, "flag after writing 1 while clear");

    // R12 software start single fast, R11 auto clear
    c = cyc;
    push(c + 1 + plen(0, 0), 2'b01, 1'b1, "R12 R5 R8");
    wr(mk(1, 2'd0, 0, 0, 0, 0));
    chk("R12", busy, 1, "busy right after software start");
    wait_until(c + plen(0, 0) + 3);
    chk("R11", rd_data[0], 0, "start auto-cleared in single");
    chk("R5", busy, 0, "busy low after pass");

    // R10 flag sticky / cleared by 0
    wr(mk(0, 2'd0, 0, 0, 0, 1));
    chk("R10", end_flag, 1, "flag kept by write of 1");
    wr(mk(0, 2'd0, 0, 0, 0, 0));
    chk("R10", end_flag, 0, "flag cleared by write of 0");

    // R4 triggers ignored while disabled
    pulse(1, 1, 1);
    repeat (8) @(negedge clk);
    chk("R4", busy, 0, "busy with triggers disabled");

    // R4 latency and R5 slow single, R6 drop while busy
    wr(mk(0, 2'd0, 1, 0, 1, 0));
    c = cyc;
    push(c + 3 + plen(1, 0), 2'b01, 1'b1, "R4 R5");
    pulse(0, 1, 0);
    chk("R4", busy, 0, "busy before third edge");
    @(negedge clk);
    chk("R4", busy, 1, "busy after third edge");
    pulse(1, 0, 0);
    pulse(0, 0, 1);
    wait_until(c + 2 + plen(1, 0));
    chk("R6", busy, 1, "busy at last cycle of pass");
    @(negedge clk);
    chk("R5", busy, 0, "busy falls after exact length");
    repeat (10) @(negedge clk);
    chk("R6", busy, 0, "dropped triggers not served");
    chk("R11", rd_data[0], 0, "start cleared after hardware single");
    wr(mk(0, 2'd0, 1, 0, 1, 0));

    // R8 scan2 per-completion flag, R11 start kept
    wr(mk(0, 2'd1, 1, 0, 0, 0));
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b10, 1'b1, "R8");
    pulse(0, 0, 1);
    wait_until(c + 5 + plen(0, 1));
    chk("R11", rd_data[0], 1, "start kept in scan mode");

    // R3 config locked while started
    wr(mk(1, 2'd3, 0, 1, 1, 1));
    chk("R3", rd_data, mk(1, 2'd1, 1, 0, 0, 1), "locked fields");
    wr(mk(1, 2'd1, 1, 0, 0, 0));
    chk("R10", end_flag, 0, "flag cleared while started");

    // R9 both-groups policy, group 1 first
    wr(mk(0, 2'd1, 1, 0, 0, 0));
    wr(mk(0, 2'd1, 1, 1, 0, 0));
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b10, 1'b0, "R9");
    pulse(0, 0, 1);
    wait_until(c + 5 + plen(0, 1));
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b01, 1'b1, "R9");
    pulse(1, 0, 0);
    wait_until(c + 5 + plen(0, 1));
    wr(mk(1, 2'd1, 1, 1, 0, 0));
    // R9 group 0 first
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b01, 1'b0, "R9");
    pulse(0, 1, 0);
    wait_until(c + 5 + plen(0, 1));
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b10, 1'b1, "R9");
    pulse(0, 0, 1);
    wait_until(c + 5 + plen(0, 1));
    wr(mk(1, 2'd1, 1, 1, 0, 0));

    // R7 simultaneous triggers
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b01, 1'b0, "R7");
    push(c + 3 + 2 * plen(0, 1), 2'b10, 1'b1, "R7");
    pulse(1, 0, 1);
    wait_until(c + 3 + plen(0, 1));
    chk("R7", busy, 1, "busy continues into group 1 pass");
    wait_until(c + 5 + 2 * plen(0, 1));
    chk("R7", busy, 0, "busy low after both passes");
    wr(mk(1, 2'd1, 1, 1, 0, 0));

    // R9 latches cleared by stopping
    c = cyc;
    push(c + 3 + plen(0, 1), 2'b01, 1'b0, "R9");
    pulse(0, 1, 0);
    wait_until(c + 5 + plen(0, 1));
    wr(mk(0, 2'd1, 1, 1, 0, 0));
    c2 = cyc;
    push(c2 + 3 + plen(0, 1), 2'b10, 1'b0, "R9");
    pulse(0, 0, 1);
    wait_until(c2 + 5 + plen(0, 1));
    chk("R9", end_flag, 0, "flag after stop cleared latches");
    wr(mk(0, 2'd1, 1, 1, 0, 0));

    // R8 policy bit ignored in scan4
    wr(mk(0, 2'd2, 1, 1, 0, 0));
    c = cyc;
    push(c + 3 + plen(0, 2), 2'b10, 1'b1, "R8");
    pulse(0, 0, 1);
    wait_until(c + 5 + plen(0, 2));
    wr(mk(0, 2'd2, 1, 1, 0, 0));

    // R5 scan8 slow via software start
    wr(mk(0, 2'd3, 0, 0, 1, 0));
    c = cyc;
    push(c + 1 + plen(1, 3), 2'b01, 1'b1, "R5");
    wr(mk(1, 2'd3, 0, 0, 1, 0));
    wait_until(c + 3 + plen(1, 3));
    chk("R11", rd_data[0], 1, "start kept after scan8 pass");
    chk("R5", busy, 0, "busy low after scan8 pass");

    repeat (5) @(negedge clk);
    chk("R6", sbq.size(), 0, "outstanding expected completions");
    finished = 1;
    summary();
    $finish;
  end

endmodule